// File: doc/BRIEF.md
# Synchronous Read Port Output Register

This block is the registered output stage of a memory read port. The raw word coming out of a storage array enters on `rd_raw`. The block captures it on the active clock edge and presents it on `rd_q`. A clock enable decides whether a new word is taken on an edge. When the enable is low, the register keeps its value.

Three constants set the register's value in three situations:

- **Power-up value:** the register holds it from time zero.
- **Asynchronous reset value:** forced at once while `arst` is high.
- **Synchronous clear value:** loaded on an active edge when `sclr` applies.

A build-time choice sets how the enable and the synchronous clear interact. In the gated mode the clear acts only on edges where the enable is also high. In the dominant mode the clear acts on every active edge, whatever the enable does. A second build-time choice picks whether the register updates on the rising or the falling clock edge.

Top module: `sync_read_stage`

## Requirements
- R1: Before any clock edge and with `arst` low, `rd_q` equals the power-up constant `PWRUP_VAL`.
- R2: While `arst` is high, `rd_q` equals `ARST_VAL`. This holds immediately, without a clock edge, and regardless of `ce`, `sclr` or the clock.
- R3: On an active edge with `arst` low, `ce` = 1 and `sclr` = 0, `rd_q` takes the value that `rd_raw` had at that edge.
- R4: On an active edge with `arst` low, `ce` = 0 and `sclr` = 0, `rd_q` keeps its previous value.
- R5: With `CE_GATES_CLR` = 1, an active edge with `ce` = 1 and `sclr` = 1 loads `SCLR_VAL`. An active edge with `ce` = 0 and `sclr` = 1 leaves `rd_q` unchanged.
- R6: With `CE_GATES_CLR` = 0, every active edge with `sclr` = 1 loads `SCLR_VAL`, whatever `ce` is.
- R7: With `RISE_EDGE` = 1 the register updates only on rising edges of `clk`. With `RISE_EDGE` = 0 it updates only on falling edges. `rd_q` does not change on the other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is set by `RISE_EDGE` |
| arst | input | 1 | Asynchronous reset, active high |
| sclr | input | 1 | Synchronous clear request, active high |
| ce | input | 1 | Clock enable, active high |
| rd_raw | input | WIDTH | Raw word read from the array |
| rd_q | output | WIDTH | Registered read data |

## Verification
A wrong decision between hold, load and clear would show on `rd_q` right after the active edge that made it. The very next sample after that edge exposes it. The ordering of enable and clear is the easiest thing to get wrong. The sweep therefore covers every combination of `ce` and `sclr` in both modes, with a distinct data word on each step so that a stale or swapped word cannot pass. A register bound to the wrong clock edge shows up half a cycle early or late. The bench samples between the two edges to catch this, and it checks the asynchronous reset without any clock edge in between.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_TAKE = 2'd1,
    ACT_CLR  = 2'd2
  } srs_act_e;

  // Decide what an active edge does, given the priority mode.
  function automatic srs_act_e pick_action(input logic ce_gates_clr,
                                           input logic ce,
                                           input logic sclr);
    srs_act_e a;
    if (ce_gates_clr) begin
      if (!ce)       a = ACT_KEEP;
      else if (sclr) a = ACT_CLR;
      else           a = ACT_TAKE;
    end else begin
      if (sclr)      a = ACT_CLR;
      else if (ce)   a = ACT_TAKE;
      else           a = ACT_KEEP;
    end
    return a;
  endfunction

endpackage

// File: rtl/srs_decide.sv
module srs_decide
  import srs_pkg::*;
#(
  parameter int unsigned     WIDTH        = 8,
  parameter bit              CE_GATES_CLR = 1'b1,
  parameter logic [WIDTH-1:0] SCLR_VAL    = '0
) (
  input  logic             ce,
  input  logic             sclr,
  input  logic [WIDTH-1:0] rd_raw,
  output logic             upd,
  output logic             clr_evt,
  output logic [WIDTH-1:0] nxt
);

  srs_act_e act;

  always_comb begin
    act     = pick_action(CE_GATES_CLR, ce, sclr);
    upd     = (act != ACT_KEEP);
    clr_evt = (act == ACT_CLR);
    nxt     = clr_evt ? SCLR_VAL : rd_raw;
  end

endmodule

// File: rtl/srs_flop.sv
module srs_flop #(
  parameter int unsigned      WIDTH     = 8,
  parameter bit               RISE_EDGE = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL  = '0,
  parameter logic [WIDTH-1:0] PWRUP_VAL = '0
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             upd,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r = PWRUP_VAL;

  generate
    if (RISE_EDGE) begin : g_rise
      always_ff @(posedge clk or posedge arst) begin
        if (arst)     q_r <= ARST_VAL;
        else if (upd) q_r <= nxt;
      end
    end else begin : g_fall
      always_ff @(negedge clk or posedge arst) begin
        if (arst)     q_r <= ARST_VAL;
        else if (upd) q_r <= nxt;
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/sync_read_stage.sv
module sync_read_stage #(
  parameter int unsigned      WIDTH        = 8,
  parameter bit               RISE_EDGE    = 1'b1,
  parameter bit               CE_GATES_CLR = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL     = 8'h00,
  parameter logic [WIDTH-1:0] SCLR_VAL     = 8'h00,
  parameter logic [WIDTH-1:0] PWRUP_VAL    = 8'h00
) (
  input  logic             clk,
  input  logic             arst,
  input  logic             sclr,
  input  logic             ce,
  input  logic [WIDTH-1:0] rd_raw,
  output logic [WIDTH-1:0] rd_q
);

  // Named internal events, brought out for the checker.
  logic             ev_update;
  logic             ev_clear;
  logic [WIDTH-1:0] nxt_word;

  srs_decide #(
    .WIDTH       (WIDTH),
    .CE_GATES_CLR(CE_GATES_CLR),
    .SCLR_VAL    (SCLR_VAL)
  ) u_decide (
    .ce      (ce),
    .sclr    (sclr),
    .rd_raw  (rd_raw),
    .upd     (ev_update),
    .clr_evt (ev_clear),
    .nxt     (nxt_word)
  );

  srs_flop #(
    .WIDTH    (WIDTH),
    .RISE_EDGE(RISE_EDGE),
    .ARST_VAL (ARST_VAL),
    .PWRUP_VAL(PWRUP_VAL)
  ) u_flop (
    .clk (clk),
    .arst(arst),
    .upd (ev_update),
    .nxt (nxt_word),
    .q   (rd_q)
  );

endmodule

// File: rtl/sync_read_stage_chk.sv
module sync_read_stage_chk #(
  parameter int unsigned      WIDTH        = 8,
  parameter bit               RISE_EDGE    = 1'b1,
  parameter bit               CE_GATES_CLR = 1'b1,
  parameter logic [WIDTH-1:0] ARST_VAL     = 8'h00,
  parameter logic [WIDTH-1:0] SCLR_VAL     = 8'h00
) (
  input logic             clk,
  input logic             arst,
  input logic             sclr,
  input logic             ce,
  input logic [WIDTH-1:0] rd_raw,
  input logic [WIDTH-1:0] rd_q,
  input logic             ev_update,
  input logic             ev_clear
);

  logic smp;
  assign smp = RISE_EDGE ? clk : ~clk;

  // R2: asynchronous reset value is present whenever reset is sampled high
  a_r2_arst_value: assert property (@(posedge smp) arst |-> rd_q == ARST_VAL);

  // R3
  a_r3_take_word: assert property (@(posedge smp) disable iff (arst)
    (!arst && ce && !sclr) |=> rd_q == $past(rd_raw));

  // R4
  a_r4_keep_word: assert property (@(posedge smp) disable iff (arst)
    (!arst && !ce && !sclr) |=> $stable(rd_q));

  // R5 / R6: a clear event lands the clear constant on the next sample
  a_r5_clear_lands: assert property (@(posedge smp) disable iff (arst)
    (!arst && ev_clear) |=> rd_q == SCLR_VAL);

  generate
    if (CE_GATES_CLR) begin : g_gated
      // R5
      a_r5_clear_gated: assert property (@(posedge smp) disable iff (arst)
        (!arst && sclr && !ce) |=> $stable(rd_q));
      a_r5_no_event: assert property (@(posedge smp) disable iff (arst)
        (sclr && !ce) |-> !ev_update);
    end else begin : g_dominant
      // R6
      a_r6_clear_dominant: assert property (@(posedge smp) disable iff (arst)
        (!arst && sclr) |=> rd_q == SCLR_VAL);
      a_r6_event_raised: assert property (@(posedge smp) disable iff (arst)
        sclr |-> ev_clear);
    end
  endgenerate

endmodule

bind sync_read_stage sync_read_stage_chk #(
  .WIDTH       (WIDTH),
  .RISE_EDGE   (RISE_EDGE),
  .CE_GATES_CLR(CE_GATES_CLR),
  .ARST_VAL    (ARST_VAL),
  .SCLR_VAL    (SCLR_VAL)
) u_chk (
  .clk      (clk),
  .arst     (arst),
  .sclr     (sclr),
  .ce       (ce),
  .rd_raw   (rd_raw),
  .rd_q     (rd_q),
  .ev_update(ev_update),
  .ev_clear (ev_clear)
);

// File: tb/sim_sync_read_stage.sv
`timescale 1ns/1ps
module sim_sync_read_stage;

  localparam logic [7:0] A0 = 8'hA5, C0 = 8'h3C, P0 = 8'h5A;
  localparam logic [7:0] A1 = 8'h81, C1 = 8'h18, P1 = 8'hE7;

  logic       clk = 1'b0;
  logic       arst = 1'b0;
  logic       sclr = 1'b0;
  logic       ce = 1'b0;
  logic [7:0] raw = 8'h00;
  logic [7:0] q0, q1;
  logic [7:0] m0, m1;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // u0: rising edge, enable gates the clear
  sync_read_stage #(.WIDTH(8), .RISE_EDGE(1'b1), .CE_GATES_CLR(1'b1),
    .ARST_VAL(A0), .SCLR_VAL(C0), .PWRUP_VAL(P0)) u0 (
    .clk(clk), .arst(arst), .sclr(sclr), .ce(ce), .rd_raw(raw), .rd_q(q0));

  // u1: falling edge, clear dominates the enable
  sync_read_stage #(.WIDTH(8), .RISE_EDGE(1'b0), .CE_GATES_CLR(1'b0),
    .ARST_VAL(A1), .SCLR_VAL(C1), .PWRUP_VAL(P1)) u1 (
    .clk(clk), .arst(arst), .sclr(sclr), .ce(ce), .rd_raw(raw), .rd_q(q1));

  function automatic logic [7:0] model(input logic [7:0] m, input bit gated,
    input logic e, input logic c, input logic [7:0] d, input logic [7:0] cv);
    if (gated) return e ? (c ? cv : d) : m;
    return c ? cv : (e ? d : m);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // One stimulus step: drive after a rising edge, check u1 after the
  // falling edge (u0 not yet moved), then both after the rising edge.
  task automatic step(input logic e, input logic c, input logic [7:0] d, input string req);
    logic [7:0] n0, n1;
    @(posedge clk); #2;
    ce = e; sclr = c; raw = d;
    n0 = model(m0, 1'b1, e, c, d, C0);
    n1 = model(m1, 1'b0, e, c, d, C1);
    @(negedge clk); #1;
    chk({req, "/R7 u1 falling"}, q1, n1);
    chk("R7 u0 idle on falling", q0, m0);
    m0 = n0; m1 = n1;
    @(posedge clk); #1;
    chk({req, " u0"}, q0, m0);
    chk({req, "/R7 u1 idle on rising"}, q1, m1);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected done");
      finish_up();
    end
  end

  initial begin
    #1;
    chk("R1 u0 power-up", q0, P0);
    chk("R1 u1 power-up", q1, P1);
    m0 = P0; m1 = P1;

    // R4: hold from the power-up value
    step(1'b0, 1'b0, 8'h11, "R4 hold");

    // R2: asynchronous reset between edges
    @(posedge clk); #2;
    arst = 1'b1; #1;
    chk("R2 u0 immediate", q0, A0);
    chk("R2 u1 immediate", q1, A1);
    ce = 1'b1; sclr = 1'b1; raw = 8'hFF;
    @(negedge clk); #1;
    chk("R2 u1 held over edge", q1, A1);
    @(posedge clk); #1;
    chk("R2 u0 held over edge", q0, A0);
    #1; ce = 1'b0; sclr = 1'b0; arst = 1'b0;
    m0 = A0; m1 = A1;

    step(1'b1, 1'b0, 8'h42, "R3 take");
    step(1'b0, 1'b1, 8'h99, "R5/R6 clear with ce low");
    step(1'b1, 1'b0, 8'h77, "R3 take");
    step(1'b1, 1'b1, 8'h66, "R5/R6 clear with ce high");

    // Exhaustive sweep over ce/sclr with distinct words
    for (int i = 0; i < 64; i++) begin
      logic [7:0] d;
      d = 8'((i * 29 + 7) & 8'hFF);
      step(1'(i & 1), 1'((i >> 1) & ((i >> 3) | 1) & 1), d,
           ((i & 2) != 0) ? "R5/R6 sweep clear" : (((i & 1) != 0) ? "R3 sweep" : "R4 sweep"));
    end

    done = 1'b1;
    finish_up();
  end

endmodule